// File: doc/BRIEF.md
# Gate-Driver Fault Manager with Clear Timer

This block is the protection logic that sits between the sensing front end of a three-phase gate driver and its gate logic. It takes two digitised measurements: the low-side logic supply rail and the over-current sense voltage. Each arrives as an unsigned millivolt sample with a valid strobe. The block turns each measurement into a clean level by comparing it with hysteresis. It then blanks short over-current spikes and drives an active-low fault output and a shutdown signal for the gate logic.

Once every fault cause has disappeared, the fault does not release at once. A clear timer first runs for a programmable number of clock cycles, and if any cause comes back during that interval the timer starts over. A bypass input removes this interval, and the fault then releases as soon as the cause is gone. Threshold voltages, the blanking window and the clear interval are parameters. Time is counted in cycles of the single block clock.

Each sample input has a valid strobe and no ready signal. The block accepts a sample in every cycle and never applies back-pressure. A cycle with the strobe low carries no sample, and the comparator keeps its previous decision.

Top module: `fault_mgr`

## Requirements
- R1: After reset, `fault_n` is 0 and `shutdown` is 1, and the supply is treated as under-voltage. The fault is held until a valid supply sample above the upper threshold has been seen.
- R2: The supply is judged good after a valid sample strictly above `UV_HI_MV` (default 8900) and under-voltage after a valid sample strictly below `UV_LO_MV` (default 8200). A sample between the two thresholds leaves the judgement unchanged.
- R3: The trip level goes active after a valid sample strictly above `TRIP_HI_MV` (default 460) and inactive after a valid sample strictly below `TRIP_LO_MV` (default 400). A sample between the two thresholds leaves the level unchanged.
- R4: An active trip level lasting `BLANK_CYC` cycles (default 33) or fewer raises no fault. When the level persists longer, `fault_n` falls on the `BLANK_CYC+2`-th rising edge, counting from the edge that captures the first over-threshold sample.
- R5: A valid supply sample below the lower threshold drives `fault_n` low on the 2nd rising edge, counting from the edge that captures it.
- R6: With `clr_bypass` at 0, `fault_n` rises on the `CLR_CYC+2`-th rising edge (default `CLR_CYC` is 1000), counting from the edge that captures the sample that removed the last fault cause.
- R7: If a fault cause returns while the clear timer runs, `fault_n` stays 0 and the full clear interval restarts once the cause is gone again.
- R8: When both causes are present, the clear timer does not start until both have gone.
- R9: With `clr_bypass` at 1, `fault_n` rises on the 2nd rising edge, counting from the edge that captures the sample that removed the last cause.
- R10: `shutdown` is the inverse of `fault_n` in every cycle.
- R11: A cycle whose valid strobe is low has no effect, whatever value is on the sample bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_valid | input | 1 | Supply sample strobe |
| vcc_mv | input | MV_W | Supply sample, unsigned millivolts |
| trip_valid | input | 1 | Trip-sense sample strobe |
| trip_mv | input | MV_W | Trip-sense sample, unsigned millivolts |
| clr_bypass | input | 1 | 1: release without the clear interval |
| fault_n | output | 1 | Fault output, active low |
| shutdown | output | 1 | Gate shutdown request, active high |

## Verification
The hardest state to reach is a cause returning partway through the clear interval, or one cause still present after the other has cleared. In either case the output must not move, so nothing at the ports shows the error until a full interval later. The stimulus sets up these cases deliberately. It lets the clear timer run for half its length and then reinjects under-voltage. It also removes the supply fault while a confirmed trip is still held and removes the trip last. Each release is then measured edge by edge from the sample that removed the final cause. The blanking boundary is hit exactly by holding the trip level for `BLANK_CYC` cycles and then for one cycle more.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    FM_LATCHED  = 2'd0,
    FM_CLEARING = 2'd1,
    FM_RUN      = 2'd2
  } fm_state_e;
endpackage

// File: rtl/fm_hyst_cmp.sv
module fm_hyst_cmp #(
  parameter int W       = 16,
  parameter int HI_MV   = 8900,
  parameter int LO_MV   = 8200,
  parameter bit RST_LVL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_mv,
  output logic         lvl
);
  localparam logic [W-1:0] HI_V = W'(HI_MV);
  localparam logic [W-1:0] LO_V = W'(LO_MV);

  logic above_hi;
  logic below_lo;

  always_comb begin
    above_hi = smp_valid && (smp_mv > HI_V);
    below_lo = smp_valid && (smp_mv < LO_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= RST_LVL;
    end else if (above_hi) begin
      lvl <= 1'b1;
    end else if (below_lo) begin
      lvl <= 1'b0;
    end
  end

  AST_HYST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (smp_mv > HI_V) |=> lvl); // R2 R3
  AST_HYST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (smp_mv < LO_V) |=> !lvl); // R3
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid || ((smp_mv >= LO_V) && (smp_mv <= HI_V))) |=> $stable(lvl)); // R11
endmodule

// File: rtl/fm_blanker.sv
module fm_blanker #(
  parameter int BLANK_CYC = 33
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_lvl,
  output logic trip_ok
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!trip_lvl) begin
      run_cnt <= '0;
    end else if (run_cnt != LIMIT) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_comb trip_ok = trip_lvl && (run_cnt == LIMIT);

  AST_BLANK_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ok |-> $past(trip_lvl)); // R4
  AST_BLANK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_lvl |=> (run_cnt == '0)); // R4
endmodule

// File: rtl/fm_clear_ctrl.sv
module fm_clear_ctrl
  import fm_pkg::*;
#(
  parameter int CLR_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  input  logic bypass,
  output logic fault_n
);
  localparam int TW = $clog2(CLR_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(CLR_CYC - 1);

  fm_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      FM_LATCHED: begin
        tmr_d = '0;
        if (!cause) state_d = bypass ? FM_RUN : FM_CLEARING;
      end
      FM_CLEARING: begin
        if (cause) begin
          state_d = FM_LATCHED;
          tmr_d   = '0;
        end else if (bypass || tmr_q == LAST) begin
          state_d = FM_RUN;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      FM_RUN: begin
        tmr_d = '0;
        if (cause) state_d = FM_LATCHED;
      end
      default: begin
        state_d = FM_LATCHED;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FM_LATCHED;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  always_comb fault_n = (state_q == FM_RUN);

  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> !fault_n); // R5
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> (tmr_q == '0)); // R7
  AST_RELEASE_AFTER_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) && !$past(bypass) |-> $past(tmr_q) == LAST); // R6
  AST_BYPASS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && !cause && (state_q != FM_RUN) |=> fault_n); // R9
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr #(
  parameter int MV_W       = 16,
  parameter int UV_HI_MV   = 8900,
  parameter int UV_LO_MV   = 8200,
  parameter int TRIP_HI_MV = 460,
  parameter int TRIP_LO_MV = 400,
  parameter int BLANK_CYC  = 33,
  parameter int CLR_CYC    = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vcc_valid,
  input  logic [MV_W-1:0] vcc_mv,
  input  logic            trip_valid,
  input  logic [MV_W-1:0] trip_mv,
  input  logic            clr_bypass,
  output logic            fault_n,
  output logic            shutdown
);
  logic vcc_good;
  logic trip_lvl;
  logic trip_ok;
  logic any_cause;

  fm_hyst_cmp #(
    .W(MV_W), .HI_MV(UV_HI_MV), .LO_MV(UV_LO_MV), .RST_LVL(1'b0)
  ) u_vcc_cmp (
    .clk(clk), .rst_n(rst_n), .smp_valid(vcc_valid), .smp_mv(vcc_mv), .lvl(vcc_good)
  );

  fm_hyst_cmp #(
    .W(MV_W), .HI_MV(TRIP_HI_MV), .LO_MV(TRIP_LO_MV), .RST_LVL(1'b0)
  ) u_trip_cmp (
    .clk(clk), .rst_n(rst_n), .smp_valid(trip_valid), .smp_mv(trip_mv), .lvl(trip_lvl)
  );

  fm_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .trip_lvl(trip_lvl), .trip_ok(trip_ok)
  );

  always_comb any_cause = !vcc_good || trip_ok;

  fm_clear_ctrl #(.CLR_CYC(CLR_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cause(any_cause), .bypass(clr_bypass), .fault_n(fault_n)
  );

  always_comb shutdown = !fault_n;

  AST_SHUTDOWN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown != fault_n); // R10
  AST_UV_HOLDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_good |=> !fault_n); // R1
  AST_BOTH_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_good || trip_ok) |=> !fault_n); // R8
endmodule

// File: tb/fault_mgr_tb_top.sv
`timescale 1ns/1ps
module fault_mgr_tb_top;
  localparam int BLANK = 33;
  localparam int CLR   = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vcc_valid = 1'b0;
  logic [15:0] vcc_mv = '0;
  logic        trip_valid = 1'b0;
  logic [15:0] trip_mv = '0;
  logic        clr_bypass = 1'b0;
  logic        fault_n;
  logic        shutdown;

  int n_chk = 0;
  int n_err = 0;
  int shut_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fault_mgr #(.BLANK_CYC(BLANK), .CLR_CYC(CLR)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .vcc_valid(vcc_valid), .vcc_mv(vcc_mv),
    .trip_valid(trip_valid), .trip_mv(trip_mv),
    .clr_bypass(clr_bypass), .fault_n(fault_n), .shutdown(shutdown)
  );

  always @(negedge clk) if (rst_n && (shutdown == fault_n)) shut_bad++;

  typedef struct packed {
    logic [15:0] vcc;
    logic [15:0] trip;
    logic        byp;
    logic [15:0] hold;
    logic        exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'd9500, 16'd0,   1'b0, 16'd1100, 1'b1, 8'd6},  // R6 first release
    '{16'd8500, 16'd0,   1'b0, 16'd20,   1'b1, 8'd2},  // R2 hold good
    '{16'd8100, 16'd0,   1'b0, 16'd5,    1'b0, 8'd5},  // R5
    '{16'd8500, 16'd0,   1'b0, 16'd1100, 1'b0, 8'd2},  // R2 hold UV
    '{16'd9000, 16'd0,   1'b0, 16'd1100, 1'b1, 8'd6},  // R6
    '{16'd9000, 16'd500, 1'b0, 16'd20,   1'b1, 8'd4},  // R4 within blanking
    '{16'd9000, 16'd500, 1'b0, 16'd30,   1'b0, 8'd4},  // R4 past blanking
    '{16'd9000, 16'd430, 1'b0, 16'd1100, 1'b0, 8'd3},  // R3 hold active
    '{16'd9000, 16'd380, 1'b0, 16'd1100, 1'b1, 8'd3},  // R3 inactive
    '{16'd9000, 16'd500, 1'b1, 16'd50,   1'b0, 8'd4},  // R4 bypass mode
    '{16'd9000, 16'd0,   1'b1, 16'd3,    1'b1, 8'd9},  // R9
    '{16'd9000, 16'd0,   1'b0, 16'd5,    1'b1, 8'd9}   // R9 back to normal
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int v, input int t, input bit b);
    vcc_mv = 16'(v); trip_mv = 16'(t); clr_bypass = b;
    vcc_valid = 1'b1; trip_valid = 1'b1;
  endtask

  // counts rising edges until fault_n equals lvl; called right after driving at a falling edge
  task automatic measure(input logic lvl, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (fault_n !== lvl && n < limit);
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    int lat;
    int stuck;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", fault_n, 0);
    check("R10", shutdown, 1);
    rst_n = 1'b1;
    wait_cyc(50);
    check("R1", fault_n, 0);
    trip_valid = 1'b1; trip_mv = 16'd0;
    wait_cyc(CLR + 50);
    check("R1", fault_n, 0);

    foreach (VECS[i]) begin
      drive(VECS[i].vcc, VECS[i].trip, VECS[i].byp);
      repeat (VECS[i].hold) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (fault_n !== VECS[i].exp) begin
        n_err++;
        $display("FAIL R%0d vector %0d: actual %0d expected %0d",
                 VECS[i].req, i, fault_n, VECS[i].exp);
      end
    end

    // R4: exactly BLANK cycles of trip level is ignored
    drive(9000, 500, 0);
    wait_cyc(BLANK);
    drive(9000, 0, 0);
    stuck = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (fault_n !== 1'b1) stuck++;
    end
    check("R4", stuck, 0);

    // R4 latency one cycle longer, then R6 release latency
    drive(9000, 500, 0);
    measure(1'b0, 200, lat);
    check("R4", lat, BLANK + 2);
    drive(9000, 0, 0);
    measure(1'b1, 3 * CLR, lat);
    check("R6", lat, CLR + 2);

    // R5: under-voltage latency
    drive(8000, 0, 0);
    measure(1'b0, 20, lat);
    check("R5", lat, 2);

    // R7: cause returns mid-interval
    drive(9500, 0, 0);
    wait_cyc(CLR / 2);
    check("R7", fault_n, 0);
    drive(8000, 0, 0);
    wait_cyc(3);
    check("R7", fault_n, 0);
    drive(9500, 0, 0);
    measure(1'b1, 3 * CLR, lat);
    check("R7", lat, CLR + 2);

    // R8: both causes, supply cleared first
    drive(8000, 500, 0);
    wait_cyc(BLANK + 10);
    drive(9500, 500, 0);
    wait_cyc(CLR + 100);
    check("R8", fault_n, 0);
    drive(9500, 0, 0);
    measure(1'b1, 3 * CLR, lat);
    check("R8", lat, CLR + 2);

    // R11: strobes low, garbage on buses
    vcc_valid = 1'b0; trip_valid = 1'b0;
    vcc_mv = 16'd0; trip_mv = 16'd5000;
    stuck = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (fault_n !== 1'b1) stuck++;
    end
    check("R11", stuck, 0);

    // R9: bypass release latency
    drive(8000, 0, 1);
    wait_cyc(5);
    drive(9500, 0, 1);
    measure(1'b1, 50, lat);
    check("R9", lat, 2);

    check("R10", shut_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule